// File: doc/BRIEF.md
# Extended Match Channel Bank

This block holds eight match channels, numbered 4 through 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks one of five rate strobes that drive the counter, or stops it. It chooses whether the channel compares its own counter or the counter of its group leader. It also sets clear-on-match, free-running re-arm and snapshot capture. An external tick generator supplies one single-cycle strobe for each rate, and software reaches all state through a simple register read/write port.

A match occurs when the compared count first equals the match value. It sets the status bit whose position equals the channel number, provided that channel's enable bit is set. All eight channels share one interrupt line, which is high while any of their status bits is set. The group leaders are channels 4, 8 and 10. Channels 5 to 7 can follow channel 4, channel 9 can follow 8 and channel 11 can follow 10. Reading the counter of channel 9 or 11 can also freeze the current count of its partner (8 or 10) into a snapshot register.

Top module: `xm_bank`

## Requirements
- R1: After reset, every counter, match value, control word, the enable register, the status register and the snapshot read as 0, and `irq` is low.
- R2: Byte addresses: the counter of channel c is at 0x40+4*(c-4), its match value at 0x80+4*(c-4) and its control word at 0xC0+4*(c-4). Status is at 0x14, enables at 0x1C (bit c belongs to channel c, and only bits 11:4 are kept) and the snapshot at 0x20. Read data is registered and is valid in the cycle after `reg_re`.
- R3: Control bits [2:0] select the rate. Code k in 1..5 counts on `rate_tick[k-1]` (1=32768 Hz, 2=1 kHz, 3=1 Hz, 4=1 MHz, 5=external). Codes 0, 6 and 7 stop the counter. A running counter adds 1 in each cycle its strobe is high.
- R4: A counter write takes effect at the next clock edge and takes priority over a strobe in the same cycle.
- R5: When control bit 7 is 1, the channel compares its own counter. When bit 7 is 0, it compares the counter of its leader (4 for channels 4-7, 8 for 8-9, 10 for 10-11). A channel that is not a leader and has bit 7 clear never advances its own counter.
- R6: A match is the cycle in which the compared count equals the match value after being unequal in the previous cycle. The next edge sets the status bit of that channel only if its enable bit is 1.
- R7: With control bit 3 set, a match clears the channel's own counter at the next edge, in place of any increment.
- R8: With control bit 6 set, every new match fires. With bit 6 clear, the channel fires once and then stays silent until its counter, match value or control word is written.
- R9: Channels 4-7 keep control bits 7:0 and channels 8-11 keep bits 9:0; the other bits read as 0. On channels 8-11, bit 8 = 1 stops the counter whatever the rate code.
- R10: A counter read of channel 9 or 11 with its control bit 9 set copies the own counter of channel 8 or 10 into the snapshot. Without bit 9, the snapshot is left unchanged.
- R11: Writing 1s to status clears those bits. A match that sets a bit in the same cycle wins over the clear.
- R12: `irq` is high exactly when at least one status bit is set. It falls at the edge where a status write leaves none set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_tick | input | 5 | Single-cycle rate strobes, bit k-1 for rate code k |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Shared match interrupt |

## Verification
A channel's match and a software write-1-to-clear of the same status bit can land on the same clock edge. The bench provokes this by raising the rate strobe that carries a counter onto its match value, and then issuing the status clear in the very next cycle, which is the cycle the match fires. It judges the result by reading status back and checking that the bit is still set and `irq` is still high. A separate write in the same cycle as a rate strobe checks that the loaded value wins over the increment.

// File: rtl/xm_pkg.sv
package xm_pkg;
  localparam int NCH     = 8;
  localparam int CH_BASE = 4;
  localparam int NRATE   = 5;
  localparam int CTLW    = 10;
  localparam int ADDR_W  = 8;

  localparam int CB_RST  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_HALT = 8;
  localparam int CB_SNAP = 9;

  // local channel index (0..NCH-1) of the counter a channel follows
  function automatic int leader_of(input int i);
    if (i < 4) return 0;
    return i & ~1;
  endfunction
endpackage

// File: rtl/xm_channel.sv
module xm_channel
  import xm_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit IS_LEADER = 1'b1,
  parameter bit WIDE      = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NRATE-1:0] tick,
  input  logic            wr_cnt,
  input  logic            wr_match,
  input  logic            wr_ctl,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   grp_cnt,
  output logic [DW-1:0]   cnt,
  output logic [DW-1:0]   match_val,
  output logic [CTLW-1:0] ctl,
  output logic            fire
);
  localparam logic [CTLW-1:0] CTL_KEEP = WIDE ? 10'h3FF : 10'h0FF;

  logic [DW-1:0]   cnt_q, match_q;
  logic [CTLW-1:0] ctl_q;
  logic            eq_q, armed_q;
  logic            tick_sel, halted, adv, eq;
  logic [DW-1:0]   cmp;

  always_comb begin
    tick_sel = 1'b0;
    for (int r = 1; r <= NRATE; r++)
      if (int'(ctl_q[2:0]) == r) tick_sel = tick[r-1];
  end

  assign halted = WIDE && ctl_q[CB_HALT];
  assign adv    = (IS_LEADER || ctl_q[CB_OWN]) && !halted && tick_sel;
  assign cmp    = ctl_q[CB_OWN] ? cnt_q : grp_cnt;
  assign eq     = (cmp == match_q);
  assign fire   = eq && !eq_q && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctl_q   <= '0;
      eq_q    <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      eq_q <= eq;
      if (wr_cnt)                      cnt_q <= wdata;
      else if (fire && ctl_q[CB_RST])  cnt_q <= '0;
      else if (adv)                    cnt_q <= cnt_q + DW'(1);
      if (wr_match) match_q <= wdata;
      if (wr_ctl)   ctl_q   <= wdata[CTLW-1:0] & CTL_KEEP;
      if (wr_cnt || wr_match || wr_ctl)  armed_q <= 1'b1;
      else if (fire && !ctl_q[CB_PER])   armed_q <= 1'b0;
    end
  end

  assign cnt       = cnt_q;
  assign match_val = match_q;
  assign ctl       = ctl_q;

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(wr_cnt) |-> cnt_q == $past(wdata)); // R4
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($past(fire) && $past(ctl_q[CB_RST]) && !$past(wr_cnt)) |-> cnt_q == '0); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_cnt) && !$past(fire) && $past(ctl_q[2:0]) == 3'd0) |-> cnt_q == $past(cnt_q)); // R3
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    (fire && !ctl_q[CB_PER] && !wr_cnt && !wr_match && !wr_ctl) |=> !fire); // R8
endmodule

// File: rtl/xm_status.sv
module xm_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] ien,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] ien_q, stat_q, stat_d;
  logic         irq_q;

  always_comb begin
    stat_d = stat_q;
    if (clr_we) stat_d = stat_d & ~wmask;
    stat_d = stat_d | (fire & ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (en_we) ien_q <= wmask;
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end

  assign ien    = ien_q;
  assign status = stat_q;
  assign irq    = irq_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !(clr_we && wmask[i])) |=> stat_q[i]); // R11
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (fire[i] && ien_q[i]) |=> stat_q[i]); // R11
    AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_q[i]) |-> $past(ien_q[i])); // R6
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == (stat_q != '0)); // R12
endmodule

// File: rtl/xm_bank.sv
module xm_bank
  import xm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRATE-1:0]  rate_tick,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SNAP   = 8'h20;
  localparam int IDXW = $clog2(NCH);

  logic [DW-1:0]   cnt_arr   [NCH];
  logic [DW-1:0]   match_arr [NCH];
  logic [CTLW-1:0] ctl_arr   [NCH];
  logic [NCH-1:0]  fire, ien, status;
  logic [DW-1:0]   snap_q, rd_mux, rdata_q;

  logic            aligned, in_cnt, in_match, in_ctl;
  logic [IDXW-1:0] idx;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign in_cnt   = aligned && (reg_addr[7:5] == 3'b010);
  assign in_match = aligned && (reg_addr[7:5] == 3'b100);
  assign in_ctl   = aligned && (reg_addr[7:5] == 3'b110);
  assign idx      = reg_addr[2 +: IDXW];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int LDR = leader_of(k);
    logic sel;
    assign sel = (idx == IDXW'(k));
    xm_channel #(
      .DW       (DW),
      .IS_LEADER(LDR == k),
      .WIDE     (k >= 4)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (rate_tick),
      .wr_cnt   (reg_we && in_cnt && sel),
      .wr_match (reg_we && in_match && sel),
      .wr_ctl   (reg_we && in_ctl && sel),
      .wdata    (reg_wdata),
      .grp_cnt  (cnt_arr[LDR]),
      .cnt      (cnt_arr[k]),
      .match_val(match_arr[k]),
      .ctl      (ctl_arr[k]),
      .fire     (fire[k])
    );
  end

  xm_status #(.N(NCH)) u_status (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .en_we (reg_we && reg_addr == OFF_IEN),
    .clr_we(reg_we && reg_addr == OFF_STATUS),
    .wmask (reg_wdata[CH_BASE +: NCH]),
    .ien   (ien),
    .status(status),
    .irq   (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (in_cnt)                      rd_mux = cnt_arr[idx];
    else if (in_match)               rd_mux = match_arr[idx];
    else if (in_ctl)                 rd_mux = DW'(ctl_arr[idx]);
    else if (reg_addr == OFF_STATUS) rd_mux = DW'({status, 4'b0000});
    else if (reg_addr == OFF_IEN)    rd_mux = DW'({ien, 4'b0000});
    else if (reg_addr == OFF_SNAP)   rd_mux = snap_q;
  end

  // channels 9 and 11 are local indices 5 and 7; their partner is one below
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (reg_re) begin
      rdata_q <= rd_mux;
      if (in_cnt && idx[0] && idx[2] && ctl_arr[idx][CB_SNAP])
        snap_q <= cnt_arr[{idx[IDXW-1:1], 1'b0}];
    end
  end

  assign reg_rdata = rdata_q;

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (reg_re && in_cnt && idx == IDXW'(5) && ctl_arr[5][CB_SNAP]) |=> snap_q == $past(cnt_arr[4])); // R10
  AST_SNAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_re) |-> $stable(snap_q)); // R10
endmodule

// File: tb/xm_bank_bench.sv
module xm_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  tick = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  xm_bank u_xm_bank (
    .clk(clk), .rst(rst), .rate_tick(tick), .reg_we(we), .reg_re(re),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] a_cnt(int ch);   return 8'(8'h40 + 4*(ch-4)); endfunction
  function automatic logic [7:0] a_match(int ch); return 8'(8'h80 + 4*(ch-4)); endfunction
  function automatic logic [7:0] a_ctl(int ch);   return 8'(8'hC0 + 4*(ch-4)); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(int b, int n);
    for (int i = 0; i < n; i++) begin
      tick[b] = 1'b1;
      @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R2 map
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int c = 4; c < 12; c++) begin
      rd(a_cnt(c), v);   chk("R1 counter", v, 0);
      rd(a_match(c), v); chk("R1 match", v, 0);
      rd(a_ctl(c), v);   chk("R1 control", v, 0);
    end
    rd(8'h14, v); chk("R1 status", v, 0);
    rd(8'h1C, v); chk("R1 enable", v, 0);
    rd(8'h20, v); chk("R1 snapshot", v, 0);

    // R2 / R9 register sweep
    for (int c = 4; c < 12; c++) begin
      wr(a_match(c), 32'hA500_0000 | c);
      wr(a_cnt(c), 32'h1234_0000 | c);
      wr(a_ctl(c), 32'hFFFF_FFFF);
    end
    for (int c = 4; c < 12; c++) begin
      rd(a_match(c), v); chk("R2 match readback", v, 32'hA500_0000 | c);
      rd(a_cnt(c), v);   chk("R2 counter readback", v, 32'h1234_0000 | c);
      rd(a_ctl(c), v);   chk("R9 control width", v, (c < 8) ? 32'hFF : 32'h3FF);
    end
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R2 enable width", v, 32'hFF0);
    for (int c = 4; c < 12; c++) begin
      wr(a_ctl(c), 0);
      wr(a_match(c), 32'hFFFF_FFF0);
    end
    wr(8'h14, 32'hFFF);

    // R3 rate sweep on channel 4
    for (int code = 0; code < 8; code++) begin
      wr(a_ctl(4), code);
      wr(a_cnt(4), 0);
      for (int b = 0; b < 5; b++) pulse(b, b + 1);
      rd(a_cnt(4), v);
      chk("R3 rate select", v, (code >= 1 && code <= 5) ? code : 0);
    end
    wr(a_ctl(4), 0);

    // R9 halt bit on channel 8
    wr(a_cnt(8), 0);
    wr(a_ctl(8), 32'h101);
    pulse(0, 3);
    rd(a_cnt(8), v); chk("R9 halt bit", v, 0);
    wr(a_ctl(8), 0);

    // R4 write beats strobe
    wr(a_ctl(4), 32'h84);
    tick[3] = 1'b1; we = 1'b1; addr = a_cnt(4); wdata = 100;
    @(negedge clk);
    tick = '0; we = 1'b0;
    rd(a_cnt(4), v); chk("R4 write over tick", v, 100);
    pulse(3, 1);
    rd(a_cnt(4), v); chk("R3 count after load", v, 101);
    wr(a_ctl(4), 0);

    // R5 / R6 / R12 group following for every follower
    begin
      int fol [5] = '{5, 6, 7, 9, 11};
      for (int j = 0; j < 5; j++) begin
        int f = fol[j];
        int l = (f < 8) ? 4 : (f & ~1);
        wr(a_cnt(l), 0);
        wr(a_cnt(f), 32'h10);
        wr(a_match(f), 2);
        wr(a_ctl(f), 1);
        wr(a_ctl(l), 1);
        pulse(0, 2);
        idle(1);
        rd(8'h14, v); chk("R5 follower matches leader", v, 32'h1 << f);
        chk("R12 irq high", {31'b0, irq}, 1);
        rd(a_cnt(f), v); chk("R5 follower own counter frozen", v, 32'h10);
        wr(8'h14, 32'hFF0);
        chk("R12 irq dropped", {31'b0, irq}, 0);
        rd(8'h14, v); chk("R11 status cleared", v, 0);
        wr(a_ctl(l), 0);
        wr(a_ctl(f), 0);
        wr(a_match(f), 32'hFFFF_FFF0);
      end
    end

    // R5 own counter mode, R6 enable gating
    wr(a_cnt(5), 0);
    wr(a_match(5), 2);
    wr(a_ctl(5), 32'h81);
    pulse(0, 2); idle(1);
    rd(8'h14, v); chk("R5 own counter match", v, 32'h20);
    wr(8'h14, 32'hFF0);
    wr(8'h1C, 32'hFF0 & ~32'h20);
    wr(a_cnt(5), 0);
    pulse(0, 2); idle(1);
    rd(8'h14, v); chk("R6 disabled channel no status", v, 0);
    chk("R6 disabled channel no irq", {31'b0, irq}, 0);
    wr(8'h1C, 32'hFF0);
    wr(a_ctl(5), 0);

    // R7 / R8 periodic with clear on channel 10
    wr(a_cnt(10), 0);
    wr(a_match(10), 3);
    wr(a_ctl(10), 32'hCC);
    pulse(3, 3); idle(1);
    rd(a_cnt(10), v); chk("R7 cleared on match", v, 0);
    rd(8'h14, v); chk("R8 first periodic match", v, 32'h400);
    wr(8'h14, 32'h400);
    pulse(3, 3); idle(1);
    rd(8'h14, v); chk("R8 second periodic match", v, 32'h400);
    wr(8'h14, 32'h400);
    wr(a_ctl(10), 0);

    // R8 one-shot on channel 11
    wr(a_cnt(11), 0);
    wr(a_match(11), 2);
    wr(a_ctl(11), 32'h8C);
    pulse(3, 2); idle(1);
    rd(8'h14, v); chk("R8 one-shot fires", v, 32'h800);
    wr(8'h14, 32'h800);
    pulse(3, 2); idle(1);
    rd(8'h14, v); chk("R8 one-shot silent", v, 0);
    rd(a_cnt(11), v); chk("R7 no clear without match", v, 2);
    wr(a_cnt(11), 0);
    pulse(3, 2); idle(1);
    rd(8'h14, v); chk("R8 re-armed by counter write", v, 32'h800);
    wr(8'h14, 32'h800);
    wr(a_ctl(11), 0);

    // R11 match and clear on the same edge
    wr(a_cnt(4), 4);
    wr(a_match(4), 5);
    wr(a_ctl(4), 32'h84);
    tick[3] = 1'b1;
    @(negedge clk);
    tick = '0; we = 1'b1; addr = 8'h14; wdata = 32'h10;
    @(negedge clk);
    we = 1'b0;
    rd(8'h14, v); chk("R11 set beats clear", v, 32'h10);
    chk("R12 irq after collision", {31'b0, irq}, 1);
    wr(8'h14, 32'h10);
    chk("R12 irq after clear", {31'b0, irq}, 0);
    wr(a_ctl(4), 0);

    // R10 snapshot
    wr(a_cnt(8), 32'h77);
    wr(a_ctl(9), 32'h200);
    rd(a_cnt(9), v);
    rd(8'h20, v); chk("R10 snapshot of channel 8", v, 32'h77);
    wr(a_cnt(10), 32'h55);
    wr(a_ctl(11), 0);
    rd(a_cnt(11), v);
    rd(8'h20, v); chk("R10 snapshot unchanged", v, 32'h77);
    wr(a_ctl(11), 32'h200);
    rd(a_cnt(11), v);
    rd(8'h20, v); chk("R10 snapshot of channel 10", v, 32'h55);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule